// File: doc/BRIEF.md
# Hit-Count Coincidence Trigger

This block turns per-channel discriminator strobes from a group of photodetector channels into a single detector-wide trigger decision. Every strobe opens two square windows on its channel, one short and one long, each a fixed number of clock cycles wide. Every clock the block counts how many channels have an open window of each width. Each count is compared against its own programmable threshold.

Each width is a separate trigger type. A type fires when its count is strictly above its threshold, and a fired type passes only if its bit is set in a programmable enable mask. When any enabled type fires and no lockout is running, the block emits a one-cycle global trigger pulse. With the pulse it presents a sequence ID and the set of types that caused it, so the data captured downstream can later be matched to the trigger. The long-window count is meant to be the main physics trigger. The short-window count serves tighter coincidences.

Configuration goes through a simple write port: two thresholds, the enable mask and a lockout length.

Top module: `hitcount_trigger`

## Requirements
- R1: After reset the pulse output, ID output and type output are all zero. Both thresholds reset to all ones and the enable mask resets to zero, so no trigger can be issued until the block is configured.
- R2: A strobe sampled on a clock edge keeps the channel's short window open for SHORT_W cycles and its long window open for LONG_W cycles, starting with the cycle after that edge.
- R3: A strobe on a channel whose window is already open restarts that window at its full width. The channel still adds only one to the count.
- R4: For each width, the count is the number of channels with that window open. A type fires when its count is strictly greater than its threshold.
- R5: Type bit 0 is the short window and type bit 1 is the long window. A fired type can raise the global trigger only if the matching mask bit is 1. The type output shows only fired types that are also enabled.
- R6: The global trigger is high for exactly one cycle per issue. When the count crosses the threshold because of strobes sampled on edge E, the pulse appears after edge E+2.
- R7: After an issue with lockout value L, no further issue happens for the next L cycles. While the condition persists, the issues come every L+1 cycles.
- R8: The ID of the first trigger after reset is 0. Each later trigger carries the previous ID plus one, modulo 2^ID_W.
- R9: The ID output and type output hold their values between pulses.
- R10: Write addresses are: 0 for the short threshold, 1 for the long threshold, 2 for the enable mask (bits 1:0) and 3 for the lockout length in cycles. A write takes effect on the edge where cfg_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | N_CH | Discriminator strobes, one per channel |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| gtrig_o | output | 1 | One-cycle global trigger pulse |
| gtrig_id_o | output | ID_W | Sequence ID of the latest trigger |
| gtrig_type_o | output | 2 | Enabled types that fired for the latest trigger |

## Verification
The bench builds the block with 8 channels, windows of 2 and 10 cycles, and a 4-bit ID. With 8 channels, every hit multiplicity from 0 to 8 can be swept against every threshold from 0 to 8 for both widths. Every configuration can be checked against the simple rule "count greater than threshold". The 4-bit ID wraps many times during the sweep, so wrap-around is checked at every pulse. The short windows keep the pulse-count arithmetic for lockout and window restart small enough to state exactly.

// File: rtl/hct_pkg.sv
package hct_pkg;

    localparam int NTYPES   = 2;
    localparam int TT_SHORT = 0;
    localparam int TT_LONG  = 1;

    typedef logic [NTYPES-1:0] ttype_t;

    typedef enum logic [1:0] {
        CFG_THR_SHORT = 2'd0,
        CFG_THR_LONG  = 2'd1,
        CFG_MASK      = 2'd2,
        CFG_LOCKOUT   = 2'd3
    } cfg_addr_e;

    // strict comparison of a window count against its threshold
    function automatic logic above(input int unsigned count, input int unsigned thr);
        return count > thr;
    endfunction

endpackage

// File: rtl/hct_stretch.sv
module hct_stretch #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic active
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (hit)
            cnt <= CW'(W);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign active = (cnt != '0);

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt == CW'(W)));

    p_count_r3: assert property (@(posedge clk) disable iff (rst)
        (!hit && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));

endmodule

// File: rtl/hct_window_sum.sv
module hct_window_sum
    import hct_pkg::*;
#(
    parameter int N_CH  = 32,
    parameter int SUM_W = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NTYPES-1:0][N_CH-1:0]       act,
    output logic [NTYPES-1:0][SUM_W-1:0]      sum
);
    logic [NTYPES-1:0][SUM_W-1:0] sum_d;

    always_comb begin
        for (int t = 0; t < NTYPES; t++) begin
            sum_d[t] = '0;
            for (int c = 0; c < N_CH; c++)
                sum_d[t] = sum_d[t] + SUM_W'(act[t][c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sum <= '0;
        else     sum <= sum_d;
    end

    p_bound_short_r4: assert property (@(posedge clk) disable iff (rst)
        32'(sum[TT_SHORT]) <= N_CH);

    p_bound_long_r4: assert property (@(posedge clk) disable iff (rst)
        32'(sum[TT_LONG]) <= N_CH);

endmodule

// File: rtl/hct_cfg_regs.sv
module hct_cfg_regs
    import hct_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [1:0]                        addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NTYPES-1:0][DATA_W-1:0]     thr,
    output ttype_t                            mask,
    output logic [DATA_W-1:0]                 lockout
);
    logic unused_mask_bits;
    assign unused_mask_bits = ^wdata[DATA_W-1:NTYPES];

    always_ff @(posedge clk) begin
        if (rst) begin
            thr     <= '1;
            mask    <= '0;
            lockout <= '0;
        end else if (we) begin
            unique case (cfg_addr_e'(addr))
                CFG_THR_SHORT: thr[TT_SHORT] <= wdata;
                CFG_THR_LONG:  thr[TT_LONG]  <= wdata;
                CFG_MASK:      mask          <= wdata[NTYPES-1:0];
                CFG_LOCKOUT:   lockout       <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/hct_trig_eval.sv
module hct_trig_eval
    import hct_pkg::*;
#(
    parameter int SUM_W  = 6,
    parameter int DATA_W = 16,
    parameter int ID_W   = 24
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NTYPES-1:0][SUM_W-1:0]      sum,
    input  logic [NTYPES-1:0][DATA_W-1:0]     thr,
    input  ttype_t                            mask,
    input  logic [DATA_W-1:0]                 lockout,
    output logic                              gtrig,
    output logic [ID_W-1:0]                   id,
    output ttype_t                            ttype
);
    ttype_t            fired;
    logic              issue;
    logic [DATA_W-1:0] lock_cnt;
    logic [ID_W-1:0]   id_next;

    always_comb begin
        for (int t = 0; t < NTYPES; t++)
            fired[t] = above(int'(sum[t]), int'(thr[t])) & mask[t];
    end

    assign issue = (|fired) && (lock_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            gtrig    <= 1'b0;
            id       <= '0;
            id_next  <= '0;
            ttype    <= '0;
            lock_cnt <= '0;
        end else begin
            gtrig <= issue;
            if (issue) begin
                id       <= id_next;
                id_next  <= id_next + ID_W'(1);
                ttype    <= fired;
                lock_cnt <= lockout;
            end else if (lock_cnt != '0) begin
                lock_cnt <= lock_cnt - DATA_W'(1);
            end
        end
    end

    p_type_r5: assert property (@(posedge clk) disable iff (rst)
        gtrig |-> (ttype != '0));

    p_mask_r5: assert property (@(posedge clk) disable iff (rst)
        gtrig |-> ((ttype & ~$past(mask)) == '0));

    p_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (gtrig && lock_cnt != '0) |=> !gtrig);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !gtrig |-> ($stable(id) && $stable(ttype)));

endmodule

// File: rtl/hitcount_trigger.sv
module hitcount_trigger
    import hct_pkg::*;
#(
    parameter int N_CH    = 32,
    parameter int SHORT_W = 2,
    parameter int LONG_W  = 10,
    parameter int DATA_W  = 16,
    parameter int ID_W    = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   hit_i,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              gtrig_o,
    output logic [ID_W-1:0]   gtrig_id_o,
    output logic [1:0]        gtrig_type_o
);
    localparam int SUM_W = $clog2(N_CH + 1);

    logic [NTYPES-1:0][N_CH-1:0]   act;
    logic [NTYPES-1:0][SUM_W-1:0]  sum;
    logic [NTYPES-1:0][DATA_W-1:0] thr;
    ttype_t                        mask;
    logic [DATA_W-1:0]             lockout;
    ttype_t                        ttype;

    for (genvar t = 0; t < NTYPES; t++) begin : g_type
        localparam int WID = (t == TT_SHORT) ? SHORT_W : LONG_W;
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            hct_stretch #(.W(WID)) u_str (
                .clk    (clk),
                .rst    (rst),
                .hit    (hit_i[c]),
                .active (act[t][c])
            );
        end
    end

    hct_window_sum #(.N_CH(N_CH), .SUM_W(SUM_W)) u_sum (
        .clk (clk),
        .rst (rst),
        .act (act),
        .sum (sum)
    );

    hct_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .thr     (thr),
        .mask    (mask),
        .lockout (lockout)
    );

    hct_trig_eval #(.SUM_W(SUM_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_eval (
        .clk     (clk),
        .rst     (rst),
        .sum     (sum),
        .thr     (thr),
        .mask    (mask),
        .lockout (lockout),
        .gtrig   (gtrig_o),
        .id      (gtrig_id_o),
        .ttype   (ttype)
    );

    assign gtrig_type_o = ttype;

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!gtrig_o && gtrig_id_o == '0 && gtrig_type_o == '0));

endmodule

// File: tb/sim_hitcount_trigger.sv
module sim_hitcount_trigger;
    localparam int N     = 8;
    localparam int SW    = 2;
    localparam int LW    = 10;
    localparam int DW    = 16;
    localparam int IW    = 4;
    localparam int SPAN  = 45;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  hit = '0;
    logic          we = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          gtrig;
    logic [IW-1:0] gid;
    logic [1:0]    gtype;

    int checks = 0;
    int errors = 0;
    int exp_id = 0;
    int np, first, ftype;

    always #5 clk = ~clk;

    hitcount_trigger #(.N_CH(N), .SHORT_W(SW), .LONG_W(LW), .DATA_W(DW), .ID_W(IW)) u0 (
        .clk(clk), .rst(rst), .hit_i(hit), .cfg_we(we), .cfg_addr(addr),
        .cfg_wdata(wdata), .gtrig_o(gtrig), .gtrig_id_o(gid), .gtrig_type_o(gtype)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        we = 1'b1; addr = 2'(a); wdata = DW'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    // drive pattern v once; optionally drive v2 at sample index gap
    task automatic run(input logic [N-1:0] v, input int gap, input logic [N-1:0] v2,
                       output int pulses, output int fpos, output int fty);
        pulses = 0; fpos = -1; fty = 0;
        @(negedge clk); hit = v;
        @(negedge clk); hit = '0;
        for (int j = 0; j < SPAN; j++) begin
            if (gtrig) begin
                chk(int'(gid) == exp_id, "R8 id", int'(gid), exp_id);
                exp_id = (exp_id + 1) % (1 << IW);
                if (pulses == 0) begin fpos = j; fty = int'(gtype); end
                pulses++;
            end
            if (j == gap) hit = v2;
            else hit = '0;
            @(negedge clk);
        end
        if (pulses > 0) begin
            chk(int'(gid) == (exp_id + (1 << IW) - 1) % (1 << IW), "R9 id hold",
                int'(gid), (exp_id + (1 << IW) - 1) % (1 << IW));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(gtrig == 1'b0, "R1 pulse", int'(gtrig), 0);
        chk(gid == '0, "R1 id", int'(gid), 0);
        chk(gtype == '0, "R1 type", int'(gtype), 0);
        run('1, -1, '0, np, first, ftype);
        chk(np == 0, "R1 unconfigured no trigger", np, 0);

        // R4 R5 R6 R10 sweep of multiplicity against threshold, both widths
        wr(3, 40);
        for (int ty = 0; ty < 2; ty++) begin
            wr(2, 1 << ty);
            for (int t = 0; t <= N; t++) begin
                wr(ty, t);
                wr(1 - ty, 0);
                for (int k = 0; k <= N; k++) begin
                    run(N'((1 << k) - 1), -1, '0, np, first, ftype);
                    chk(np == ((k > t) ? 1 : 0), "R4 fire on count above threshold", np, (k > t) ? 1 : 0);
                    if (np > 0) begin
                        chk(first == 2, "R6 latency", first, 2);
                        chk(ftype == (1 << ty), "R5 type bits", ftype, 1 << ty);
                    end
                end
            end
        end

        // R2 window widths, lockout zero
        wr(3, 0);
        wr(0, 0); wr(1, 0);
        wr(2, 1);
        run(8'h10, -1, '0, np, first, ftype);
        chk(np == SW, "R2 short width", np, SW);
        wr(2, 2);
        run(8'h10, -1, '0, np, first, ftype);
        chk(np == LW, "R2 long width", np, LW);

        // R7 lockout spacing
        wr(3, 3);
        run(8'h01, -1, '0, np, first, ftype);
        chk(np == (LW + 3) / 4, "R7 lockout 3", np, (LW + 3) / 4);
        wr(3, 1);
        run(8'h01, -1, '0, np, first, ftype);
        chk(np == (LW + 1) / 2, "R7 lockout 1", np, (LW + 1) / 2);

        // R3 restart without double count
        wr(3, 0);
        run(8'h01, 4, 8'h01, np, first, ftype);
        chk(np == LW + 5, "R3 restart extends window", np, LW + 5);
        wr(1, 1);
        run(8'h01, 4, 8'h01, np, first, ftype);
        chk(np == 0, "R3 counted once", np, 0);

        // R5 masking
        wr(3, 40);
        wr(0, 0); wr(1, 0);
        wr(2, 0);
        run('1, -1, '0, np, first, ftype);
        chk(np == 0, "R5 all masked", np, 0);
        wr(2, 3);
        run('1, -1, '0, np, first, ftype);
        chk(np == 1 && ftype == 3, "R5 both types", ftype, 3);
        wr(0, 5);
        run(8'h0f, -1, '0, np, first, ftype);
        chk(np == 1 && ftype == 2, "R5 long only", ftype, 2);
        @(negedge clk);
        chk(int'(gtype) == 2, "R9 type hold", int'(gtype), 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule